// File: doc/BRIEF.md
# Storage FIS Receive Classifier

This block sits between a serial storage link layer and the receive FIFO of the transport layer. Double words arrive from the link as a valid/ready stream with start-of-frame and end-of-frame markers, and the end-of-frame beat carries a CRC-good flag computed upstream. Every double word is forwarded unchanged to the FIFO write port. Alongside that path the block reads the type byte of each frame's header, tracks how many double words the frame has delivered, and tells the command layer when the frame counts as received. The moment of that report depends on the frame category.

Command-style (non-data) frames and short vendor frames are reported at end of frame, and only when the CRC is good. A data frame is reported as soon as its header has been written. A vendor frame that grows past a programmable short-length limit is reported when the FIFO fill level reaches a programmable watermark. A frame whose CRC fails before it has been reported raises an error pulse instead. Its final FIFO entry is marked bad, so the command side can discard the frame.

Back-pressure rules: a beat transfers when `lnk_valid` and `lnk_ready` are both high. `lnk_ready` follows `fifo_ready` in the same cycle, so a stalled FIFO stalls the link. The block never holds or drops a beat, and `fifo_valid` is high only in a cycle where the link offers a beat. The short-length limit and the watermark are plain configuration inputs, both counted in double words.

Top module: `fis_rx_classifier`

## Requirements
- R1: Every beat presented on the link port appears in the same cycle on the FIFO port with identical data, start and end markers. `fifo_valid` equals `lnk_valid` and `lnk_ready` equals `fifo_ready`.
- R2: The category is taken from bits [7:0] of the start-of-frame double word. 0x46 is data, 0xC7 and 0xD4 are vendor, and every other value is non-data.
- R3: For a non-data frame whose end-of-frame beat transfers with CRC good, `rx_done` is high for exactly one cycle, starting the cycle after that transfer. `rx_done_type` carries the type byte during that cycle.
- R4: A frame that ends with CRC bad and has not yet been reported gives a single-cycle `rx_err` the cycle after the end beat, and no `rx_done`. The end-of-frame FIFO entry of any frame with CRC bad has `fifo_bad` = 1. All other entries have `fifo_bad` = 0.
- R5: A data frame gives `rx_done` the cycle after its header transfers. Its later end beat gives neither `rx_done` nor `rx_err`, whatever the CRC.
- R6: A vendor frame of at most `short_limit` double words, header included, behaves as a non-data frame. FIFO level is ignored for such a frame, even when it is at or above the watermark.
- R7: Once a vendor frame has transferred more than `short_limit` double words, `rx_done` follows one cycle after the first cycle in which `fifo_level` >= `watermark`.
- R8: A long vendor frame that ends before the watermark condition is met is reported at its end beat: `rx_done` if the CRC is good, `rx_err` if it is bad.
- R9: Each frame yields at most one `rx_done` or `rx_err`. The two never rise together, and `rx_done_type` is 0 whenever `rx_done` is low.
- R10: After reset the pulses are low and no frame is open. A beat with no start marker that arrives outside a frame produces no notification. A new start marker abandons an unfinished frame without reporting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| short_limit | input | LEN_W | Longest vendor frame, in double words, still treated as short |
| watermark | input | LVL_W | FIFO fill level that reports a long vendor frame |
| fifo_level | input | LVL_W | Current fill level of the receive FIFO |
| lnk_valid | input | 1 | Link offers a double word |
| lnk_ready | output | 1 | Block accepts the double word |
| lnk_data | input | DW_W | Double word from the link |
| lnk_sof | input | 1 | Beat is the frame header |
| lnk_eof | input | 1 | Beat is the last of the frame |
| lnk_crc_ok | input | 1 | CRC status, meaningful with lnk_eof |
| fifo_valid | output | 1 | Write strobe toward the FIFO |
| fifo_ready | input | 1 | FIFO has room |
| fifo_data | output | DW_W | Double word to store |
| fifo_sof | output | 1 | Stored entry is a header |
| fifo_eof | output | 1 | Stored entry ends a frame |
| fifo_bad | output | 1 | Stored entry ends a frame with CRC bad |
| rx_done | output | 1 | Single-cycle received notification |
| rx_done_type | output | 8 | Type byte of the reported frame |
| rx_err | output | 1 | Single-cycle CRC error notification |

## Verification
Faults in the frame state show up as pulses that are missing, doubled or shifted in time. A lost category or type register gives a wrong `rx_done_type`, or a pulse at the end beat where a header-time pulse was due, at most one cycle after the deciding beat. A corrupted length count or long flag moves a vendor report between the end beat and the watermark cycle, which is visible within one frame. A stuck reported flag repeats the report at the end beat, where the scoreboard counts an extra event.

// File: rtl/fis_rx_pkg.sv
package fis_rx_pkg;

  typedef enum logic [1:0] {
    CAT_CMD  = 2'd0,
    CAT_DATA = 2'd1,
    CAT_VEND = 2'd2
  } fis_cat_e;

endpackage

// File: rtl/fis_type_decode.sv
module fis_type_decode
  import fis_rx_pkg::*;
#(
  parameter logic [7:0] CODE_DATA   = 8'h46,
  parameter logic [7:0] CODE_VEND_A = 8'hC7,
  parameter logic [7:0] CODE_VEND_B = 8'hD4
) (
  input  logic [7:0] type_byte,
  output fis_cat_e   cat
);

  always_comb begin
    if (type_byte == CODE_DATA) begin
      cat = CAT_DATA;
    end else if ((type_byte == CODE_VEND_A) || (type_byte == CODE_VEND_B)) begin
      cat = CAT_VEND;
    end else begin
      cat = CAT_CMD;
    end
  end

endmodule

// File: rtl/fis_len_track.sv
module fis_len_track #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  input  logic [LEN_W-1:0] short_limit,
  output logic             is_long
);

  localparam logic [LEN_W-1:0] CNT_MAX = {LEN_W{1'b1}};
  localparam logic [LEN_W-1:0] CNT_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_now;

  // Saturating length count: the header counts as one double word.
  always_comb begin
    if (sof) begin
      cnt_now = CNT_ONE;
    end else if (cnt_q == CNT_MAX) begin
      cnt_now = cnt_q;
    end else begin
      cnt_now = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      is_long <= 1'b0;
    end else if (beat) begin
      cnt_q   <= cnt_now;
      is_long <= (cnt_now > short_limit);
    end
  end

endmodule

// File: rtl/fis_rx_notify.sv
module fis_rx_notify
  import fis_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic       sof,
  input  logic       eof,
  input  logic       crc_ok,
  input  logic [7:0] type_byte,
  input  fis_cat_e   cat_hdr,
  input  logic       is_long,
  input  logic       lvl_hit,
  output logic       done,
  output logic [7:0] done_type,
  output logic       err
);

  logic       open_q;
  logic       told_q;
  fis_cat_e   cat_q;
  logic [7:0] type_q;

  logic       start;
  logic       open_now;
  logic       told_now;
  fis_cat_e   cat_now;
  logic [7:0] type_now;
  logic       wm_fire;
  logic       hdr_fire;
  logic       end_here;
  logic       pending;
  logic       fire;
  logic       fail;

  always_comb begin
    start    = beat && sof;
    open_now = start ? 1'b1 : open_q;
    told_now = start ? 1'b0 : told_q;
    cat_now  = start ? cat_hdr : cat_q;
    type_now = start ? type_byte : type_q;

    // Watermark rule applies only to an open long vendor frame not yet reported.
    wm_fire  = open_q && !start && (cat_q == CAT_VEND) && is_long && !told_q && lvl_hit;
    hdr_fire = start && (cat_hdr == CAT_DATA);
    end_here = beat && eof && open_now;
    pending  = !(told_now || wm_fire || hdr_fire);

    fire     = wm_fire || hdr_fire || (end_here && crc_ok && pending);
    fail     = end_here && !crc_ok && pending;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      told_q    <= 1'b0;
      cat_q     <= CAT_CMD;
      type_q    <= '0;
      done      <= 1'b0;
      done_type <= '0;
      err       <= 1'b0;
    end else begin
      open_q    <= end_here ? 1'b0 : open_now;
      told_q    <= told_now || fire || fail;
      cat_q     <= cat_now;
      type_q    <= type_now;
      done      <= fire;
      done_type <= fire ? type_now : 8'h00;
      err       <= fail;
    end
  end

endmodule

// File: rtl/fis_rx_classifier.sv
module fis_rx_classifier
  import fis_rx_pkg::*;
#(
  parameter int         DW_W        = 32,
  parameter int         LEN_W       = 12,
  parameter int         LVL_W       = 10,
  parameter logic [7:0] CODE_DATA   = 8'h46,
  parameter logic [7:0] CODE_VEND_A = 8'hC7,
  parameter logic [7:0] CODE_VEND_B = 8'hD4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] short_limit,
  input  logic [LVL_W-1:0] watermark,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             lnk_valid,
  output logic             lnk_ready,
  input  logic [DW_W-1:0]  lnk_data,
  input  logic             lnk_sof,
  input  logic             lnk_eof,
  input  logic             lnk_crc_ok,
  output logic             fifo_valid,
  input  logic             fifo_ready,
  output logic [DW_W-1:0]  fifo_data,
  output logic             fifo_sof,
  output logic             fifo_eof,
  output logic             fifo_bad,
  output logic             rx_done,
  output logic [7:0]       rx_done_type,
  output logic             rx_err
);

  logic     beat;
  logic     lvl_hit;
  logic     is_long;
  fis_cat_e cat_hdr;

  // Write path: straight through, the FIFO's room back-pressures the link.
  assign lnk_ready  = fifo_ready;
  assign fifo_valid = lnk_valid;
  assign fifo_data  = lnk_data;
  assign fifo_sof   = lnk_sof;
  assign fifo_eof   = lnk_eof;
  assign fifo_bad   = lnk_eof && !lnk_crc_ok;

  assign beat    = lnk_valid && fifo_ready;
  assign lvl_hit = (fifo_level >= watermark);

  fis_type_decode #(
    .CODE_DATA   (CODE_DATA),
    .CODE_VEND_A (CODE_VEND_A),
    .CODE_VEND_B (CODE_VEND_B)
  ) u_decode (
    .type_byte (lnk_data[7:0]),
    .cat       (cat_hdr)
  );

  fis_len_track #(
    .LEN_W (LEN_W)
  ) u_len (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat        (beat),
    .sof         (lnk_sof),
    .short_limit (short_limit),
    .is_long     (is_long)
  );

  fis_rx_notify u_notify (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (beat),
    .sof       (lnk_sof),
    .eof       (lnk_eof),
    .crc_ok    (lnk_crc_ok),
    .type_byte (lnk_data[7:0]),
    .cat_hdr   (cat_hdr),
    .is_long   (is_long),
    .lvl_hit   (lvl_hit),
    .done      (rx_done),
    .done_type (rx_done_type),
    .err       (rx_err)
  );

endmodule

// File: rtl/fis_rx_classifier_chk.sv
module fis_rx_classifier_chk #(
  parameter int DW_W  = 32,
  parameter int LVL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] watermark,
  input logic [LVL_W-1:0] fifo_level,
  input logic             lnk_valid,
  input logic             lnk_ready,
  input logic [DW_W-1:0]  lnk_data,
  input logic             lnk_sof,
  input logic             lnk_eof,
  input logic             lnk_crc_ok,
  input logic             rx_done,
  input logic [7:0]       rx_done_type,
  input logic             rx_err
);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && rx_err));

  p_type_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |-> (rx_done_type == 8'h00));

  p_data_hdr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_valid && lnk_ready && lnk_sof && (lnk_data[7:0] == 8'h46))
      |=> (rx_done && (rx_done_type == 8'h46)));

  p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_valid && lnk_ready && lnk_eof && lnk_crc_ok) |=> !rx_err);

  p_done_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(lnk_valid && lnk_ready) && (fifo_level < watermark)) |=> !rx_done);

endmodule

bind fis_rx_classifier fis_rx_classifier_chk #(
  .DW_W  (DW_W),
  .LVL_W (LVL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .watermark    (watermark),
  .fifo_level   (fifo_level),
  .lnk_valid    (lnk_valid),
  .lnk_ready    (lnk_ready),
  .lnk_data     (lnk_data),
  .lnk_sof      (lnk_sof),
  .lnk_eof      (lnk_eof),
  .lnk_crc_ok   (lnk_crc_ok),
  .rx_done      (rx_done),
  .rx_done_type (rx_done_type),
  .rx_err       (rx_err)
);

// File: tb/test_fis_rx_classifier.sv
module test_fis_rx_classifier;

  localparam int DW_W  = 32;
  localparam int LEN_W = 12;
  localparam int LVL_W = 10;
  localparam int LIMIT = 6;
  localparam int WMARK = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LEN_W-1:0] short_limit = LEN_W'(LIMIT);
  logic [LVL_W-1:0] watermark = LVL_W'(WMARK);
  logic [LVL_W-1:0] fifo_level = '0;
  logic             lnk_valid = 1'b0;
  logic             lnk_ready;
  logic [DW_W-1:0]  lnk_data = '0;
  logic             lnk_sof = 1'b0;
  logic             lnk_eof = 1'b0;
  logic             lnk_crc_ok = 1'b0;
  logic             fifo_valid;
  logic             fifo_ready = 1'b1;
  logic [DW_W-1:0]  fifo_data;
  logic             fifo_sof;
  logic             fifo_eof;
  logic             fifo_bad;
  logic             rx_done;
  logic [7:0]       rx_done_type;
  logic             rx_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  // Scoreboard: kind 0 = done, 1 = error
  int q_kind[$];
  int q_type[$];
  int q_cyc[$];
  int q_req[$];

  // Reference frame state
  bit m_act = 1'b0;
  int m_cat = 0;   // 0 cmd, 1 data, 2 vendor
  int m_type = 0;
  int m_cnt = 0;
  bit m_long = 1'b0;
  bit m_told = 1'b0;

  fis_rx_classifier #(
    .DW_W  (DW_W),
    .LEN_W (LEN_W),
    .LVL_W (LVL_W)
  ) i_fis_rx_classifier (
    .clk          (clk),
    .rst_n        (rst_n),
    .short_limit  (short_limit),
    .watermark    (watermark),
    .fifo_level   (fifo_level),
    .lnk_valid    (lnk_valid),
    .lnk_ready    (lnk_ready),
    .lnk_data     (lnk_data),
    .lnk_sof      (lnk_sof),
    .lnk_eof      (lnk_eof),
    .lnk_crc_ok   (lnk_crc_ok),
    .fifo_valid   (fifo_valid),
    .fifo_ready   (fifo_ready),
    .fifo_data    (fifo_data),
    .fifo_sof     (fifo_sof),
    .fifo_eof     (fifo_eof),
    .fifo_bad     (fifo_bad),
    .rx_done      (rx_done),
    .rx_done_type (rx_done_type),
    .rx_err       (rx_err)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R2: category from the header type byte
  function automatic int classify(input int t);
    if (t == 'h46) return 1;
    if (t == 'hC7 || t == 'hD4) return 2;
    return 0;
  endfunction

  task automatic push(input int kind, input int t, input int when, input int req);
    q_kind.push_back(kind);
    q_type.push_back(t);
    q_cyc.push_back(when);
    q_req.push_back(req);
  endtask

  // One cycle of the reference model, evaluated with the inputs of the current cycle
  task automatic model(input bit acc, input bit sof, input bit eof, input bit crc,
                       input int t, input bit lvl);
    bit wm, hdr, endh, pend, fire, fail;
    int req;
    wm = m_act && !(acc && sof) && m_cat == 2 && m_long && !m_told && lvl;
    if (acc && sof) begin
      m_act = 1'b1; m_cat = classify(t); m_type = t;
      m_cnt = 0; m_long = 1'b0; m_told = 1'b0;
    end
    hdr  = acc && sof && m_cat == 1;
    endh = acc && eof && m_act;
    pend = !(m_told || wm || hdr);
    fire = wm || hdr || (endh && crc && pend);
    fail = endh && !crc && pend;
    req  = wm ? 7 : hdr ? 5 : (m_cat == 2 ? (m_long ? 8 : 6) : 3);
    if (acc && eof && m_cat == 2 && (m_cnt + 1) > LIMIT) req = 8;
    if (fire) push(0, m_type, cyc + 1, req);
    if (fail) push(1, 0, cyc + 1, 4);
    if (acc) begin
      m_cnt++;
      m_long = (m_cnt > LIMIT);
    end
    m_told = m_told || fire || fail;
    if (endh) m_act = 1'b0;
  endtask

  // Driver: sends one frame; wm_at = beat number (1-based) from which the level is high
  task automatic send_frame(input int t, input int len, input bit crc,
                            input int wm_at, input bit stall, input bit with_sof);
    int i = 0;
    while (i < len) begin
      @(negedge clk);
      lnk_valid  = 1'b1;
      lnk_data   = (i == 0) ? {24'h5A5A00 + 24'(len), 8'(t)} : $urandom;
      lnk_sof    = (i == 0) && with_sof;
      lnk_eof    = (i == len - 1);
      lnk_crc_ok = crc;
      fifo_level = (wm_at != 0 && i + 1 >= wm_at) ? LVL_W'(WMARK + 1) : LVL_W'(2);
      fifo_ready = stall ? cyc[0] : 1'b1;
      #1;
      // R1: pass-through and back-pressure
      check(fifo_valid && fifo_data == lnk_data && fifo_sof == lnk_sof &&
            fifo_eof == lnk_eof && lnk_ready == fifo_ready, "R1",
            fifo_data, lnk_data);
      // R4: bad tag only on an end beat with CRC bad
      check(fifo_bad == (lnk_eof && !crc), "R4 bad tag", fifo_bad, lnk_eof && !crc);
      model(fifo_ready, lnk_sof, lnk_eof, crc, t, fifo_level >= LVL_W'(WMARK));
      if (fifo_ready) i++;
    end
    @(negedge clk);
    lnk_valid = 1'b0; lnk_sof = 1'b0; lnk_eof = 1'b0;
    fifo_level = LVL_W'(2); fifo_ready = 1'b1;
    #1;
    check(!fifo_valid, "R1 idle", fifo_valid, 0);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares every notification with the scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (!rx_done) check(rx_done_type == 8'h00, "R9 idle type", rx_done_type, 0);
      if (rx_done && rx_err) check(1'b0, "R9 both pulses", 1, 0);
      else if (rx_done || rx_err) begin
        if (q_kind.size() == 0) begin
          check(1'b0, rx_done ? "R9 unexpected done" : "R9 unexpected err", rx_done_type, 0);
        end else begin
          int k, t, w, r;
          k = q_kind.pop_front(); t = q_type.pop_front();
          w = q_cyc.pop_front();  r = q_req.pop_front();
          checks++;
          if (k != (rx_err ? 1 : 0) || w != cyc || (rx_done && t != rx_done_type)) begin
            fails++;
            $display("FAIL R%0d: actual kind %0d type %0h cycle %0d expected kind %0d type %0h cycle %0d",
                     r, rx_err ? 1 : 0, rx_done_type, cyc, k, t, w);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(5ns * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(!rx_done && !rx_err, "R10 reset pulses", {rx_done, rx_err}, 0);
    check(rx_done_type == 8'h00, "R10 reset type", rx_done_type, 0);
    check(lnk_ready == fifo_ready, "R1 reset ready", lnk_ready, fifo_ready);

    send_frame('h34, 5, 1'b1, 0, 1'b0, 1'b1);   // R3 non-data good
    send_frame('h27, 5, 1'b0, 0, 1'b0, 1'b1);   // R4 non-data bad
    send_frame('hA1, 1, 1'b1, 0, 1'b0, 1'b1);   // R3 single double word
    send_frame('h46, 10, 1'b0, 0, 1'b0, 1'b1);  // R5 data, bad CRC later
    send_frame('h46, 7, 1'b1, 0, 1'b1, 1'b1);   // R5 data with stalls
    send_frame('hC7, 4, 1'b1, 1, 1'b0, 1'b1);   // R6 short vendor, level high
    send_frame('hD4, LIMIT, 1'b1, 0, 1'b0, 1'b1); // R6 exactly at limit
    send_frame('hC7, 12, 1'b1, 9, 1'b0, 1'b1);  // R7 watermark mid-frame
    send_frame('hD4, 10, 1'b1, 1, 1'b1, 1'b1);  // R7 level high from start, stalls
    send_frame('hD4, 9, 1'b1, 0, 1'b0, 1'b1);   // R8 long, no watermark, good
    send_frame('hC7, 9, 1'b0, 0, 1'b0, 1'b1);   // R8 long, no watermark, bad
    send_frame('hC7, 12, 1'b0, 8, 1'b0, 1'b1);  // R7 reported, then bad CRC end
    send_frame('h34, 3, 1'b1, 0, 1'b0, 1'b0);   // R10 stray beats, no start marker
    send_frame('h39, 4, 1'b1, 0, 1'b1, 1'b1);   // R3 non-data with stalls
    send_frame('h46, 1, 1'b1, 0, 1'b0, 1'b1);   // R5 header-only data frame

    repeat (4) @(negedge clk);
    finished = 1'b1;
    // R9: every expected notification was seen exactly once
    check(q_kind.size() == 0, "R9 missing notification", q_kind.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule